// File: doc/BRIEF.md
# Low-Frequency Gap Decoder and Load-Modulation Responder

The block sits behind a thresholded reader-field detector in a low-frequency tag emulator. A one-cycle pulse arrives once per carrier period. The block counts these pulses between successive rising edges of the field signal. Each measured interval becomes a 0 bit, a 1 bit, or is dropped. Accepted bits are packed first-bit-first into a fixed buffer. A long stretch with no rising edge closes the frame, and the block hands the frame out together with its bit count.

A command layer outside the block decides what to answer. It raises a request and supplies the reply bits, the reply length and the response delay. The block then waits until enough carrier periods have passed since the last accepted field edge. After that it drives a coil-load line with a Manchester reply that opens with a run of start bits. While a reply is pending or being sent, field edges are not listened to.

Top module: `lf_gap_responder`

## Requirements
- R1: After reset `coil_load`, `reply_busy` and `frame_valid` are 0. The first rising field edge after reset only starts timing and adds no bit.
- R2: An interval of 15 to 23 carrier periods between accepted rising edges stores a 0 bit.
- R3: An interval of 24 to 40 carrier periods stores a 1 bit.
- R4: An interval shorter than 15 periods stores nothing, but it still restarts the interval count.
- R5: Stored bit k (counting from 0) appears at `frame_bits[79-k]`. Bit positions beyond the frame length read 0.
- R6: At most 80 bits are stored. Later bits are dropped, and the frame reports a length of 80.
- R7: When the count since the last accepted edge reaches 41 with no new edge, the frame ends. If it holds at least one bit, `frame_valid` pulses for one cycle with `frame_len` and `frame_bits`, and the buffer empties. An empty frame gives no pulse.
- R8: The first rising edge after an end of frame only restarts timing and adds no bit.
- R9: After a request, the reply begins in the cycle after the count since the last accepted edge reaches `reply_delay - 8`. The threshold is never below 41.
- R10: The reply is 5 one-bits followed by the first `reply_len` bits of `reply_bits`, starting at bit 79. `reply_len` above 80 is treated as 80.
- R11: Each reply bit lasts 31 carrier periods. A 1 loads the coil (`coil_load` = 1) for phase periods 0 to 14 and opens it for 15 to 30. A 0 does the reverse.
- R12: Outside a reply `coil_load` is 0. A request while `reply_busy` is 1 is ignored, and field edges during a reply neither restart timing nor add bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| carrier_tick | input | 1 | One-cycle pulse per carrier period |
| field_in | input | 1 | Thresholded reader-field level |
| reply_req | input | 1 | Pulse: start a reply |
| reply_len | input | 7 | Number of payload bits in the reply |
| reply_bits | input | 80 | Payload; bit 79 is sent first |
| reply_delay | input | 8 | Response delay in carrier periods |
| frame_valid | output | 1 | One-cycle pulse: a frame has ended |
| frame_len | output | 7 | Bit count of the last frame |
| frame_bits | output | 80 | Bits of the last frame; the first received bit is at 79 |
| coil_load | output | 1 | 1 = coil loaded, 0 = coil open |
| reply_busy | output | 1 | A reply is waiting or being sent |

## Verification
A corrupted interval count or a wrong decode threshold shows up as a wrong bit in `frame_bits`. That error becomes visible at the `frame_valid` pulse that ends the frame, which comes 41 carrier periods after the last edge. A fault in the reply phase or shift state shows on `coil_load` within one bit time of 31 periods. A stale or missing resync flag turns into an extra leading bit in the next frame. Because every output is compared against a reference model on every clock, a divergence is reported in the first cycle it appears.

// File: rtl/lfg_pkg.sv
package lfg_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_WAIT = 2'd1,
    TX_SEND = 2'd2
  } tx_state_t;
endpackage

// File: rtl/lfg_interval_timer.sv
module lfg_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             field_in,
  input  logic             hold,
  output logic             edge_ok,
  output logic [CNT_W-1:0] since_edge
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic field_q;
  logic [CNT_W-1:0] cnt_q;

  // a rising edge is taken only while no reply is in progress
  assign edge_ok    = field_in & ~field_q & ~hold;
  assign since_edge = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      field_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      field_q <= field_in;
      if (edge_ok) begin
        cnt_q <= '0;
      end else if (tick && cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (rst) edge_ok |=> (since_edge == '0)); // R4
endmodule

// File: rtl/lfg_frame_packer.sv
module lfg_frame_packer #(
  parameter int CNT_W    = 8,
  parameter int MAX_BITS = 80,
  parameter int LEN_W    = 7,
  parameter int ZERO_MIN = 15,
  parameter int ONE_MIN  = 24,
  parameter int EOF_T    = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                edge_ok,
  input  logic [CNT_W-1:0]    since_edge,
  output logic                frame_valid,
  output logic [LEN_W-1:0]    frame_len,
  output logic [MAX_BITS-1:0] frame_data
);
  logic                ovf_q;
  logic [LEN_W-1:0]    nbits_q;
  logic [MAX_BITS-1:0] slot_q;
  logic [MAX_BITS-1:0] slot_sel;
  logic in_range, bit_val, room, take, long_gap, eof_fire;

  assign in_range = (since_edge >= CNT_W'(ZERO_MIN)) && (since_edge <= CNT_W'(EOF_T));
  assign bit_val  = (since_edge >= CNT_W'(ONE_MIN));
  assign room     = (nbits_q < LEN_W'(MAX_BITS));
  assign take     = edge_ok && !ovf_q && in_range && room;
  assign long_gap = !edge_ok && !ovf_q && (since_edge > CNT_W'(EOF_T));
  assign eof_fire = long_gap && (nbits_q != '0);

  // slot i receives the bit whose stream index is MAX_BITS-1-i
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_slot
    assign slot_sel[i] = (nbits_q == LEN_W'(MAX_BITS - 1 - i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (eof_fire) begin
      slot_q <= '0;
    end else if (take) begin
      for (int i = 0; i < MAX_BITS; i++) begin
        if (slot_sel[i]) slot_q[i] <= bit_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q       <= 1'b1;
      nbits_q     <= '0;
      frame_valid <= 1'b0;
      frame_len   <= '0;
      frame_data  <= '0;
    end else begin
      frame_valid <= 1'b0;
      if (edge_ok) begin
        ovf_q <= 1'b0;
        if (take) nbits_q <= nbits_q + 1'b1;
      end else if (long_gap) begin
        ovf_q <= 1'b1;
        if (eof_fire) begin
          frame_valid <= 1'b1;
          frame_len   <= nbits_q;
          frame_data  <= slot_q;
          nbits_q     <= '0;
        end
      end
    end
  end

  AST_NBITS_CAP: assert property (@(posedge clk) disable iff (rst) nbits_q <= LEN_W'(MAX_BITS)); // R6
  AST_FRAME_LEN_OK: assert property (@(posedge clk) disable iff (rst) frame_valid |-> (frame_len != '0 && frame_len <= LEN_W'(MAX_BITS))); // R7
  AST_OVF_AFTER_LONG: assert property (@(posedge clk) disable iff (rst) (!edge_ok && since_edge > CNT_W'(EOF_T)) |=> ovf_q); // R7
  AST_EDGE_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst) edge_ok |=> !ovf_q); // R8
endmodule

// File: rtl/lfg_reply_tx.sv
module lfg_reply_tx
  import lfg_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MAX_BITS = 80,
  parameter int LEN_W    = 7,
  parameter int SOF_BITS = 5,
  parameter int HALF_T   = 15,
  parameter int BIT_T    = 31,
  parameter int FDT_ADJ  = 8,
  parameter int EOF_T    = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                req,
  input  logic [LEN_W-1:0]    len,
  input  logic [MAX_BITS-1:0] data,
  input  logic [CNT_W-1:0]    fdt,
  input  logic [CNT_W-1:0]    since_edge,
  output logic                busy,
  output logic                coil_load
);
  localparam int SEQ_W   = SOF_BITS + MAX_BITS;
  localparam int REM_W   = $clog2(SEQ_W + 1);
  localparam int PH_W    = $clog2(BIT_T);
  localparam int MIN_THR = EOF_T + 1;

  tx_state_t         st_q, st_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [SEQ_W-1:0]  sh_q, sh_n;
  logic [REM_W-1:0]  rem_q, rem_n;
  logic [CNT_W-1:0]  thr_q, thr_n, thr_d;
  logic [LEN_W-1:0]  len_c;
  logic              coil_n;

  assign len_c = (len > LEN_W'(MAX_BITS)) ? LEN_W'(MAX_BITS) : len;
  assign thr_d = (fdt < CNT_W'(MIN_THR + FDT_ADJ)) ? CNT_W'(MIN_THR) : (fdt - CNT_W'(FDT_ADJ));

  always_comb begin
    st_n  = st_q;
    ph_n  = ph_q;
    sh_n  = sh_q;
    rem_n = rem_q;
    thr_n = thr_q;
    unique case (st_q)
      TX_IDLE: begin
        if (req) begin
          st_n  = TX_WAIT;
          sh_n  = {{SOF_BITS{1'b1}}, data};
          rem_n = REM_W'(SOF_BITS) + REM_W'(len_c);
          thr_n = thr_d;
        end
      end
      TX_WAIT: begin
        if (since_edge >= thr_q) begin
          st_n = TX_SEND;
          ph_n = '0;
        end
      end
      TX_SEND: begin
        if (tick) begin
          if (ph_q == PH_W'(BIT_T - 1)) begin
            ph_n  = '0;
            sh_n  = sh_q << 1;
            rem_n = rem_q - 1'b1;
            if (rem_q == REM_W'(1)) st_n = TX_IDLE;
          end else begin
            ph_n = ph_q + 1'b1;
          end
        end
      end
      default: st_n = TX_IDLE;
    endcase
    if (st_n == TX_SEND) begin
      coil_n = sh_n[SEQ_W-1] ? (ph_n < PH_W'(HALF_T)) : (ph_n >= PH_W'(HALF_T));
    end else begin
      coil_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= TX_IDLE;
      ph_q      <= '0;
      sh_q      <= '0;
      rem_q     <= '0;
      thr_q     <= '0;
      coil_load <= 1'b0;
    end else begin
      st_q      <= st_n;
      ph_q      <= ph_n;
      sh_q      <= sh_n;
      rem_q     <= rem_n;
      thr_q     <= thr_n;
      coil_load <= coil_n;
    end
  end

  assign busy = (st_q != TX_IDLE);

  AST_IDLE_OPEN: assert property (@(posedge clk) disable iff (rst) (st_q == TX_IDLE) |-> !coil_load); // R12
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst) ph_q <= PH_W'(BIT_T - 1)); // R11
  AST_WAIT_TO_SEND: assert property (@(posedge clk) disable iff (rst) (st_q == TX_WAIT && since_edge >= thr_q) |=> (st_q == TX_SEND)); // R9
  AST_SOF_LOADS: assert property (@(posedge clk) disable iff (rst) (st_q == TX_WAIT && since_edge >= thr_q) |=> coil_load); // R10
endmodule

// File: rtl/lf_gap_responder.sv
module lf_gap_responder #(
  parameter int CNT_W    = 8,
  parameter int MAX_BITS = 80,
  parameter int ZERO_MIN = 15,
  parameter int ONE_MIN  = 24,
  parameter int EOF_T    = 40,
  parameter int SOF_BITS = 5,
  parameter int HALF_T   = 15,
  parameter int BIT_T    = 31,
  parameter int FDT_ADJ  = 8,
  localparam int LEN_W   = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                carrier_tick,
  input  logic                field_in,
  input  logic                reply_req,
  input  logic [LEN_W-1:0]    reply_len,
  input  logic [MAX_BITS-1:0] reply_bits,
  input  logic [CNT_W-1:0]    reply_delay,
  output logic                frame_valid,
  output logic [LEN_W-1:0]    frame_len,
  output logic [MAX_BITS-1:0] frame_bits,
  output logic                coil_load,
  output logic                reply_busy
);
  logic             edge_ok;
  logic [CNT_W-1:0] since_edge;

  lfg_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .tick       (carrier_tick),
    .field_in   (field_in),
    .hold       (reply_busy),
    .edge_ok    (edge_ok),
    .since_edge (since_edge)
  );

  lfg_frame_packer #(
    .CNT_W(CNT_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W),
    .ZERO_MIN(ZERO_MIN), .ONE_MIN(ONE_MIN), .EOF_T(EOF_T)
  ) u_packer (
    .clk         (clk),
    .rst         (rst),
    .edge_ok     (edge_ok),
    .since_edge  (since_edge),
    .frame_valid (frame_valid),
    .frame_len   (frame_len),
    .frame_data  (frame_bits)
  );

  lfg_reply_tx #(
    .CNT_W(CNT_W), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .SOF_BITS(SOF_BITS),
    .HALF_T(HALF_T), .BIT_T(BIT_T), .FDT_ADJ(FDT_ADJ), .EOF_T(EOF_T)
  ) u_reply (
    .clk        (clk),
    .rst        (rst),
    .tick       (carrier_tick),
    .req        (reply_req),
    .len        (reply_len),
    .data       (reply_bits),
    .fdt        (reply_delay),
    .since_edge (since_edge),
    .busy       (reply_busy),
    .coil_load  (coil_load)
  );
endmodule

// File: tb/lf_gap_responder_bench.sv
`timescale 1ns/1ps
module lf_gap_responder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        field = 1'b1;
  logic        req = 1'b0;
  logic [6:0]  rlen = '0;
  logic [79:0] rbits = '0;
  logic [7:0]  fdt = 8'd208;
  logic        frame_valid, coil_load, reply_busy;
  logic [6:0]  frame_len;
  logic [79:0] frame_bits;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  lf_gap_responder u_lf_gap_responder (
    .clk(clk), .rst(rst), .carrier_tick(tick), .field_in(field),
    .reply_req(req), .reply_len(rlen), .reply_bits(rbits), .reply_delay(fdt),
    .frame_valid(frame_valid), .frame_len(frame_len), .frame_bits(frame_bits),
    .coil_load(coil_load), .reply_busy(reply_busy)
  );

  // ---------------- reference model ----------------
  int          m_cnt, m_st, m_thr, m_ph, m_bi, m_flen;
  bit          m_fq, m_ovf, m_fv, m_coil, m_tick_at;
  bit          mq[$];
  bit          rq[$];
  logic [79:0] m_fdata;

  function automatic logic [79:0] pack(input bit q[$]);
    logic [79:0] v = '0;
    foreach (q[k]) v[79-k] = q[k];
    return v;
  endfunction

  always @(posedge clk) begin
    bit acc;
    int c, lc;
    m_tick_at = tick;
    if (rst) begin
      m_cnt = 0; m_fq = 1; m_ovf = 1; mq.delete(); m_fv = 0; m_flen = 0; m_fdata = '0;
      m_st = 0; m_ph = 0; m_bi = 0; m_thr = 0; rq.delete(); m_coil = 0;
    end else begin
      acc = field && !m_fq && (m_st == 0);
      c = m_cnt;
      m_fv = 0;
      if (acc) begin
        if (!m_ovf && c >= 15 && c <= 40 && mq.size() < 80) mq.push_back(c >= 24);
        m_ovf = 0;
      end else if (!m_ovf && c > 40) begin
        m_ovf = 1;
        if (mq.size() > 0) begin
          m_fv = 1; m_flen = mq.size(); m_fdata = pack(mq); mq.delete();
        end
      end
      case (m_st)
        0: if (req) begin
             rq.delete();
             repeat (5) rq.push_back(1'b1);
             lc = (rlen > 80) ? 80 : int'(rlen);
             for (int k = 0; k < lc; k++) rq.push_back(rbits[79-k]);
             m_thr = (fdt < 49) ? 41 : int'(fdt) - 8;
             m_st = 1;
           end
        1: if (c >= m_thr) begin m_st = 2; m_ph = 0; m_bi = 0; end
        default: if (tick) begin
             if (m_ph == 30) begin
               m_ph = 0; m_bi++;
               if (m_bi == rq.size()) m_st = 0;
             end else m_ph++;
           end
      endcase
      m_coil = (m_st == 2) ? (rq[m_bi] ? (m_ph < 15) : (m_ph >= 15)) : 1'b0;
      if (acc) m_cnt = 0; else if (tick && m_cnt < 255) m_cnt++;
      m_fq = field;
    end
  end

  // ---------------- monitor ----------------
  int          fcount = 0;
  int          last_len = 0;
  logic [79:0] last_data = '0;
  bit          rec_on = 0, rec_done = 0;
  int          rec_start = 0;
  bit          wave[$];

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 190000) begin
        failures++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below 190000", cycles);
        summary_and_end();
      end
      if (!rst) begin
        checks++;
        if (frame_valid !== m_fv || (m_fv && (frame_len !== 7'(m_flen) || frame_bits !== m_fdata))) begin
          failures++;
          $display("FAIL R7 frame output: actual v=%0b len=%0d data=%h expected v=%0b len=%0d data=%h",
                   frame_valid, frame_len, frame_bits, m_fv, m_flen, m_fdata);
        end
        checks++;
        if (coil_load !== m_coil || reply_busy !== (m_st != 0)) begin
          failures++;
          $display("FAIL R11 reply output: actual coil=%0b busy=%0b expected coil=%0b busy=%0b",
                   coil_load, reply_busy, m_coil, (m_st != 0));
        end
        if (frame_valid) begin fcount++; last_len = frame_len; last_data = frame_bits; end
        if (!rec_on && coil_load) begin
          rec_on = 1; wave.delete(); rec_start = m_cnt - int'(m_tick_at);
        end else if (rec_on) begin
          if (!reply_busy) begin rec_on = 0; rec_done = 1; end
          else if (m_tick_at) wave.push_back(coil_load);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  initial begin
    int tph = 0;
    forever begin
      @(negedge clk);
      tph = (tph + 1) % 4;
      tick = (tph == 0);
    end
  end

  task automatic check(input bit ok, input string req_tag, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic edge_after(input int n);
    int seen = 0;
    while (seen < n) begin @(posedge clk); if (tick) seen++; end
    @(negedge clk) field = 1'b0;
    @(negedge clk) field = 1'b1;
    @(posedge clk);
  endtask

  task automatic silence();
    repeat (60 * 4) @(posedge clk);
  endtask

  task automatic send_reply(input int len, input logic [79:0] bits, input int delay);
    @(negedge clk);
    rlen = 7'(len); rbits = bits; fdt = 8'(delay); req = 1'b1; rec_done = 0;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic check_reply(input int nbits, input logic [79:0] bits, input int thr);
    bit exp_b;
    bit ok_shape = 1;
    int fk;
    while (!rec_done) @(negedge clk);
    check(rec_start == thr, "R9", "reply start in carrier periods", rec_start, thr);
    check(wave.size() == 31 * (5 + nbits) - 1, "R10", "reply length in samples", wave.size(), 31 * (5 + nbits) - 1);
    if (wave.size() == 31 * (5 + nbits) - 1) begin
      for (int j = 0; j < 5 + nbits; j++) begin
        exp_b = (j < 5) ? 1'b1 : bits[79 - (j - 5)];
        check(wave[31*j] == exp_b, "R10", $sformatf("reply bit %0d", j), wave[31*j], exp_b);
        for (int m = 0; m < 30; m++) begin
          if (wave[31*j + m] != ((m < 14) ? exp_b : !exp_b)) begin ok_shape = 0; fk = j; end
        end
      end
      check(ok_shape, "R11", "half-bit load pattern, first bad bit", fk, -1);
    end
  endtask

  // ---------------- test sequence ----------------
  initial begin
    int fc0;
    logic [79:0] exp;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    check(coil_load == 0 && reply_busy == 0 && frame_valid == 0, "R1", "outputs after reset", {coil_load, reply_busy, frame_valid}, 0);

    // R1: first edge after reset (20 periods) must not become a bit
    edge_after(20);
    edge_after(20); edge_after(30); edge_after(10); edge_after(16);
    edge_after(40); edge_after(24); edge_after(23); edge_after(14);
    silence();
    exp = '0; exp[79:74] = 6'b010110;
    check(fcount == 1, "R7", "frames after first burst", fcount, 1);
    check(last_len == 6, "R1", "length without post-reset edge (R4 drops 10 and 14)", last_len, 6);
    check(last_data == exp, "R5", "packed bits R2 R3", last_data[79:74], exp[79:74]);

    // R8: sync edge after end of frame is not a bit, then 1,0
    edge_after(5); edge_after(30); edge_after(18);
    silence();
    exp = '0; exp[79:78] = 2'b10;
    check(last_len == 2, "R8", "length after resync", last_len, 2);
    check(last_data == exp, "R5", "bits after resync", last_data[79:78], 2'b10);

    // R7: empty frame gives no pulse
    fc0 = fcount;
    edge_after(5);
    silence();
    check(fcount == fc0, "R7", "pulses for empty frame", fcount - fc0, 0);

    // R6: 85 one-bits, capped at 80
    edge_after(5);
    for (int k = 0; k < 85; k++) edge_after(30);
    silence();
    check(last_len == 80, "R6", "capped length", last_len, 80);
    check(last_data == {80{1'b1}}, "R6", "capped data all ones", $countones(last_data), 80);

    // R9 R10 R11 R12: reply with delay 208, extra request and field edges during it
    edge_after(5); edge_after(22); edge_after(35);
    send_reply(12, {12'hA5C, 68'h0}, 208);
    repeat (300) @(posedge clk);
    @(negedge clk) field = 1'b0; @(negedge clk) field = 1'b1;
    @(negedge clk) req = 1'b1; rlen = 7'd40; @(negedge clk) req = 1'b0;
    repeat (900) @(posedge clk);
    @(negedge clk) field = 1'b0; @(negedge clk) field = 1'b1;
    check_reply(12, {12'hA5C, 68'h0}, 200);
    exp = '0; exp[79:78] = 2'b01;
    check(last_len == 2 && last_data == exp, "R7", "frame ending during reply wait", last_len, 2);

    // R12: after the reply, a new frame holds only the new bits
    check(coil_load == 0, "R12", "coil idle after reply", coil_load, 0);
    edge_after(5); edge_after(20); edge_after(30);
    silence();
    check(last_len == 2 && last_data == exp, "R12", "frame after reply", last_len, 2);

    // R9: short delay clamps to 41, zero-length reply is start bits only
    edge_after(5);
    send_reply(0, 80'h0, 20);
    check_reply(0, 80'h0, 41);

    // R10: length above 80 is treated as 80
    edge_after(5);
    send_reply(100, {40'hF0F0_3C3C_A5, 40'h0123_4567_89}, 60);
    check_reply(80, {40'hF0F0_3C3C_A5, 40'h0123_4567_89}, 52);

    silence();
    summary_and_end();
  end
endmodule